// File: doc/BRIEF.md
# Receive and Transmit Event Status with Interrupt Masking

This unit keeps the sticky event flags for the receive and transmit halves of a packet controller, together with a per-event enable register for each half and an active-low summary byte. A receive engine and a transmit engine raise one-cycle event pulses. Each pulse sets its flag, and the flag stays set until the host writes a one to that position at the status address. The status is read back at the same address.

The host reaches the unit through a byte-wide register port. A status bit that is also enabled in its mask counts as a pending interrupt for its half. The summary byte shows each half as a low bit while that half has something pending. A single active-high `irq` output is raised while either half has a pending interrupt. The host port uses a one-cycle write strobe. Read data is combinational from the address and the current register contents.

Top module: `evt_irq_unit`

## Requirements
- R1: A pulse on `rx_evt` bit 7 (good packet), 4 (reset packet), 3 (runt), 2 (alignment), 1 (CRC) or 0 (FIFO overflow) sets the matching bit of the receive status at address 0x02 on the next clock edge. The bit holds until it is cleared.
- R2: Receive status bits 6 and 5 always read 0, even when `rx_evt` pulses those positions.
- R3: A write to 0x02 clears each receive status bit written as 1. Bits written as 0 are unchanged.
- R4: The receive mask at 0x03 is read/write. Its bits sit in the same positions as the receive status. Bits 6 and 5 of the mask read 0.
- R5: Address 0x13 reads bit 1 as 0 exactly when the AND of the receive status and the receive mask is nonzero, and as 1 otherwise. Bits 7 to 2 of that byte read 0.
- R6: On the transmit side, status bits 7 (sent OK), 5 (own packet seen), 3 (underflow), 2 (collision), 1 (sixteenth collision) and 0 (parity) are set by `tx_evt`. Those bits read at 0x00 and clear by writing ones to 0x00. The mask is at 0x01. Bits 6 and 4 of the transmit status and mask read 0.
- R7: Bit 0 at 0x13 reads 0 exactly when the AND of the transmit status and the transmit mask is nonzero.
- R8: When an event pulse and a host clear hit the same status bit in one cycle, the bit ends up set.
- R9: Reset clears all status and mask bits, so 0x13 reads 0x03 and `irq` is low.
- R10: `irq` is high exactly when bit 0 or bit 1 of the summary byte reads 0.
- R11: Writes to any address other than 0x00 to 0x03 change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rx_evt | input | 8 | Receive event pulses, one per status bit |
| tx_evt | input | 8 | Transmit event pulses, one per status bit |
| irq | output | 1 | High while any enabled event is pending |

## Verification
The assertions assume that event pulses and host writes are sampled only at clock edges, and that `reg_addr` is stable between edges. They do not assume the event inputs are clean. Pulses on the unimplemented positions are allowed and are expected to be dropped. The stimulus changes every input only on the falling clock edge. It deliberately drives invalid event bits, clear writes that collide with events, and writes to unmapped addresses, so the checked properties are exercised outside the ordinary path.

// File: rtl/evtirq_pkg.sv
package evtirq_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_TX_STAT = 5'h00;
    localparam logic [ADDR_W-1:0] A_TX_MASK = 5'h01;
    localparam logic [ADDR_W-1:0] A_RX_STAT = 5'h02;
    localparam logic [ADDR_W-1:0] A_RX_MASK = 5'h03;
    localparam logic [ADDR_W-1:0] A_SUMMARY = 5'h13;

    // implemented positions of each half
    localparam logic [DATA_W-1:0] TX_VALID = 8'hAF;
    localparam logic [DATA_W-1:0] RX_VALID = 8'h9F;

    localparam int N_BANKS = 2;
    localparam int BANK_TX = 0;
    localparam int BANK_RX = 1;

    typedef enum logic [2:0] {
        SEL_TX_STAT,
        SEL_TX_MASK,
        SEL_RX_STAT,
        SEL_RX_MASK,
        SEL_SUMMARY,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } host_req_t;

    typedef struct packed {
        logic clr;
        logic mask_we;
    } bank_ctl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            A_TX_STAT: return SEL_TX_STAT;
            A_TX_MASK: return SEL_TX_MASK;
            A_RX_STAT: return SEL_RX_STAT;
            A_RX_MASK: return SEL_RX_MASK;
            A_SUMMARY: return SEL_SUMMARY;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] bank_valid(input int idx);
        return (idx == BANK_TX) ? TX_VALID : RX_VALID;
    endfunction
endpackage

// File: rtl/evt_decode.sv
module evt_decode
    import evtirq_pkg::*;
(
    input  host_req_t req,
    output reg_sel_e  sel,
    output bank_ctl_t ctl [N_BANKS]
);
    always_comb begin
        sel = decode_addr(req.addr);
        for (int b = 0; b < N_BANKS; b++) begin
            ctl[b] = '0;
        end
        if (req.wr) begin
            case (sel)
                SEL_TX_STAT: ctl[BANK_TX].clr     = 1'b1;
                SEL_TX_MASK: ctl[BANK_TX].mask_we = 1'b1;
                SEL_RX_STAT: ctl[BANK_RX].clr     = 1'b1;
                SEL_RX_MASK: ctl[BANK_RX].mask_we = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evt_bank.sv
module evt_bank
    import evtirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] evt,
    input  bank_ctl_t         ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stat,
    output logic [DATA_W-1:0] mask,
    output logic              pending
);
    logic [DATA_W-1:0] stat_q, mask_q, clr_bits, set_bits;

    always_comb begin
        clr_bits = ctl.clr ? wdata : '0;
        set_bits = evt & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            // a same-cycle event outranks a clear of that bit
            stat_q <= ((stat_q & ~clr_bits) | set_bits) & VALID;
            if (ctl.mask_we) begin
                mask_q <= wdata & VALID;
            end
        end
    end

    assign stat    = stat_q;
    assign mask    = mask_q;
    assign pending = |(stat_q & mask_q);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evtirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rx_evt,
    input  logic [DATA_W-1:0] tx_evt,
    output logic              irq
);
    host_req_t         req;
    reg_sel_e          sel;
    bank_ctl_t         ctl   [N_BANKS];
    logic [DATA_W-1:0] evts  [N_BANKS];
    logic [DATA_W-1:0] stats [N_BANKS];
    logic [DATA_W-1:0] masks [N_BANKS];
    logic [N_BANKS-1:0] pend;
    logic [DATA_W-1:0] summary;

    logic [DATA_W-1:0] rx_stat, tx_stat, rx_mask, tx_mask;

    assign req = '{wr: reg_wr, addr: reg_addr, wdata: reg_wdata};
    assign evts[BANK_TX] = tx_evt;
    assign evts[BANK_RX] = rx_evt;

    evt_decode u_dec (
        .req (req),
        .sel (sel),
        .ctl (ctl)
    );

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        evt_bank #(.VALID(bank_valid(g))) u_bank (
            .clk     (clk),
            .rst     (rst),
            .evt     (evts[g]),
            .ctl     (ctl[g]),
            .wdata   (reg_wdata),
            .stat    (stats[g]),
            .mask    (masks[g]),
            .pending (pend[g])
        );
    end

    assign tx_stat = stats[BANK_TX];
    assign rx_stat = stats[BANK_RX];
    assign tx_mask = masks[BANK_TX];
    assign rx_mask = masks[BANK_RX];

    // active-low flags: bit index equals bank index
    assign summary = {{(DATA_W-N_BANKS){1'b0}}, ~pend};

    always_comb begin
        case (sel)
            SEL_TX_STAT: reg_rdata = tx_stat;
            SEL_TX_MASK: reg_rdata = tx_mask;
            SEL_RX_STAT: reg_rdata = rx_stat;
            SEL_RX_MASK: reg_rdata = rx_mask;
            SEL_SUMMARY: reg_rdata = summary;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = ~&summary[N_BANKS-1:0];
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evtirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] rx_evt,
    input logic              irq,
    input logic [DATA_W-1:0] rx_stat,
    input logic [DATA_W-1:0] rx_mask,
    input logic [DATA_W-1:0] tx_stat,
    input logic [DATA_W-1:0] tx_mask
);
    AST_RX_EVT_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rx_stat & ($past(rx_evt) & RX_VALID)) == ($past(rx_evt) & RX_VALID))); // R1

    AST_RX_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_RX_STAT) |-> (reg_rdata[6:5] == 2'b00)); // R2

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_RX_STAT && rx_evt == '0) |=> ((rx_stat & $past(reg_wdata)) == '0)); // R3

    AST_RX_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_RX_MASK) |=> (rx_mask == ($past(reg_wdata) & RX_VALID))); // R4

    AST_RX_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_SUMMARY) |-> (reg_rdata[1] == ((rx_stat & rx_mask) == '0))); // R5

    AST_TX_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_SUMMARY) |-> (reg_rdata[0] == ((tx_stat & tx_mask) == '0))); // R7

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_stat == '0 && tx_stat == '0 && rx_mask == '0 && tx_mask == '0)); // R9

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == A_SUMMARY) |-> (irq == (reg_rdata[1:0] != 2'b11))); // R10
endmodule

bind evt_irq_unit evt_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rx_evt    (rx_evt),
    .irq       (irq),
    .rx_stat   (rx_stat),
    .rx_mask   (rx_mask),
    .tx_stat   (tx_stat),
    .tx_mask   (tx_mask)
);

// File: tb/sim_evt_irq_unit.sv
module sim_evt_irq_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] rx_evt = '0;
    logic [7:0] tx_evt = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_rx_s = 0, m_rx_m = 0, m_tx_s = 0, m_tx_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_unit u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_evt(rx_evt), .tx_evt(tx_evt), .irq(irq)
    );

    function automatic int rx_pend();
        return ((m_rx_s & m_rx_m) != 0) ? 1 : 0;
    endfunction

    function automatic int tx_pend();
        return ((m_tx_s & m_tx_m) != 0) ? 1 : 0;
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            0:       return m_tx_s;
            1:       return m_tx_m;
            2:       return m_rx_s;
            3:       return m_rx_m;
            'h13:    return ((rx_pend() != 0) ? 0 : 2) + ((tx_pend() != 0) ? 0 : 1);
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // drive one cycle, update the model at the edge, compare after it
    task automatic step(input int a, input bit w, input int d,
                        input int rxe, input int txe, input string tag);
        int clr_rx, clr_tx;
        reg_addr  = a[4:0];
        reg_wr    = w;
        reg_wdata = d[7:0];
        rx_evt    = rxe[7:0];
        tx_evt    = txe[7:0];
        @(posedge clk);
        clr_rx = (w && a == 2) ? d : 0;
        clr_tx = (w && a == 0) ? d : 0;
        m_rx_s = ((m_rx_s & ~clr_rx) | rxe) & 'h9F;
        m_tx_s = ((m_tx_s & ~clr_tx) | txe) & 'hAF;
        if (w && a == 3) m_rx_m = d & 'h9F;
        if (w && a == 1) m_tx_m = d & 'hAF;
        @(negedge clk);
        reg_wr = 1'b0;
        rx_evt = '0;
        tx_evt = '0;
        check({tag, " rdata"}, int'(reg_rdata), exp_read(a));
        check({tag, " irq"}, int'(irq), (rx_pend() | tx_pend()));
    endtask

    task automatic read_all(input string tag);
        step(0, 0, 0, 0, 0, tag);
        step(1, 0, 0, 0, 0, tag);
        step(2, 0, 0, 0, 0, tag);
        step(3, 0, 0, 0, 0, tag);
        step('h13, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: everything clear out of reset
        read_all("R9");
        // R1, R2: every event position, including unimplemented ones
        step(2, 0, 0, 'hFF, 0, "R1 R2 all rx events");
        step(2, 0, 0, 'h60, 0, "R2 invalid rx bits");
        step('h13, 0, 0, 0, 0, "R5 masked off");
        // R4: mask write
        step(3, 1, 'hFF, 0, 0, "R4 mask all");
        step('h13, 0, 0, 0, 0, "R5 R10 pending rx");
        // R3: clear a subset, zero write keeps bits
        step(2, 1, 'h81, 0, 0, "R3 clear subset");
        step(2, 1, 'h00, 0, 0, "R3 zero write");
        // R8: event and clear collide
        step(2, 1, 'h10, 'h10, 0, "R8 event wins");
        step(2, 1, 'hFF, 0, 0, "R3 clear all");
        step('h13, 0, 0, 0, 0, "R5 nothing pending");
        // R6, R7: transmit half
        step(0, 0, 0, 0, 'hFF, "R6 all tx events");
        step('h13, 0, 0, 0, 0, "R7 tx masked");
        step(1, 1, 'h04, 0, 0, "R6 tx mask");
        step('h13, 0, 0, 0, 0, "R7 R10 tx pending");
        step(0, 1, 'h04, 0, 0, "R6 tx clear");
        step('h13, 0, 0, 0, 0, "R7 tx idle");
        // R11: writes elsewhere leave registers intact
        step(5, 1, 'hFF, 0, 0, "R11 write 0x05");
        step('h13, 1, 'hFF, 0, 0, "R11 write summary");
        step(7, 0, 0, 0, 0, "R11 unmapped read");
        read_all("R11 after stray writes");
        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int sel, a;
            sel = $urandom_range(0, 7);
            case (sel)
                0: a = 0; 1: a = 1; 2: a = 2; 3: a = 3;
                4, 5: a = 'h13; 6: a = 9; default: a = 'h1F;
            endcase
            step(a, ($urandom_range(0, 9) < 3), $urandom_range(0, 255),
                 (($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 0),
                 (($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : 0),
                 "R3 R5 R7 R8 mixed");
        end
        // R9: reset again with state loaded
        step(3, 1, 'hFF, 'hFF, 'hFF, "R9 preload");
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rx_s = 0; m_rx_m = 0; m_tx_s = 0; m_tx_m = 0;
        read_all("R9 second reset");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule